// File: doc/BRIEF.md
# Programmable Periodic Tick Interrupt Generator

This block raises a periodic interrupt that is timed by a reference-clock enable. The reference enable is a one-cycle strobe on the system clock. Software controls the block through one 8-bit control word. The top bit switches ticking on or off. The low seven bits hold a period value N. While the block is enabled, it counts reference strobes. Every N+1 strobes it emits a one-cycle interrupt pulse and then starts the next period by itself.

Each write that has the enable bit set starts the period again from zero. The first interrupt after such a write therefore comes on the (N+1)-th reference strobe that follows it. A write with the enable bit clear stops counting at once and drops any partly counted period. Reading the port always returns the last word written. The interrupt is meant to drive an interrupt controller input. Masking is done outside this block.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the control word reads 0x00 and the interrupt output is low.
- R2: The control word reads back all 8 bits exactly as last written, from the cycle after the write.
- R3: After a write with bit 7 set and period value N in bits 6:0, the first interrupt follows the (N+1)-th reference strobe after the write, and no strobe before that one raises it.
- R4: While bit 7 stays set, the interrupt repeats every N+1 reference strobes with no further writes.
- R5: A write with bit 7 set during a running period discards the strobes already counted and starts a full new period of N+1.
- R6: A write with bit 7 clear stops counting at once. No interrupt follows, however many strobes arrive, until a later write sets bit 7 again and a full period elapses.
- R7: With N = 0 and bit 7 set, every reference strobe raises the interrupt, including strobes on back-to-back cycles.
- R8: The interrupt is high for exactly the one system-clock cycle that follows the clock edge at which the ending strobe was sampled. It is low in every cycle that does not follow a sampled strobe.
- R9: A reference strobe sampled at the same edge as a register write neither counts toward the new period nor raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference-clock enable strobe, one system cycle per reference period |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data: bit 7 is the enable, bits 6:0 are the period value N |
| rd_data | output | 8 | Current control word |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
A down-counter with a wrong value shows up at the ports as an interrupt on the wrong strobe. This is seen within one period of the restarting write, at most 128 reference strobes. A run flag that disagrees with the enable bit shows up as pulses after a disabling write, or as no pulse at all after an enabling one. A strobe that is counted when it should be dropped shows up as an interrupt one strobe early. The bench therefore counts strobes one at a time against the expected pulse positions. It also checks that the interrupt stays low in the idle cycles between strobes.

// File: rtl/tick_pkg.sv
// tick_pkg: types and defaults shared by the periodic tick generator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package tick_pkg;
    localparam int DEF_PERIOD_W = 7;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/tick_ctrl_reg.sv
// tick_ctrl_reg: holds the control word (enable in the top bit, period value
// below it) and decodes each write into a load or a stop request.
// Assumes: wr_en is a single-cycle strobe synchronous to clk.
module tick_ctrl_reg #(
    parameter  int PERIOD_W = tick_pkg::DEF_PERIOD_W,
    localparam int REG_W    = PERIOD_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    cfg_q,
    output logic                load_o,
    output logic                stop_o,
    output logic [PERIOD_W-1:0] load_val_o
);
    localparam int EN_BIT = PERIOD_W;

    // Store the written word verbatim for readback and later reloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    // Decode the write: an enabling write restarts, any other write halts.
    always_comb begin
        load_o     = wr_en &  wr_data[EN_BIT];
        stop_o     = wr_en & ~wr_data[EN_BIT];
        load_val_o = wr_data[PERIOD_W-1:0];
    end
endmodule

// File: rtl/tick_period_cnt.sv
// tick_period_cnt: down-counter that measures N+1 reference strobes, flags the
// strobe that ends a period and reloads from the stored period value.
// Assumes: load and stop are never high together; a write in a cycle takes
// priority over a strobe sampled in that same cycle.
module tick_period_cnt #(
    parameter int PERIOD_W = tick_pkg::DEF_PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                load,
    input  logic                stop,
    input  logic [PERIOD_W-1:0] load_val,
    input  logic [PERIOD_W-1:0] reload_val,
    output logic                running,
    output logic                expire
);
    import tick_pkg::*;

    cnt_state_e            state_q;
    logic [PERIOD_W-1:0]   cnt_q;
    logic                  at_zero;

    // Detect the strobe that closes the current period.
    always_comb begin
        at_zero = (cnt_q == '0);
        running = (state_q == CNT_RUN);
        expire  = running && ref_tick && at_zero && !load && !stop;
    end

    // Advance, reload, restart or stop the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= CNT_RUN;
            cnt_q   <= load_val;
        end else if (stop) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else if (running && ref_tick) begin
            cnt_q   <= at_zero ? reload_val : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/tick_irq_out.sv
// tick_irq_out: registers the period-end flag into a one-cycle interrupt.
// Assumes: expire is high for at most one cycle per sampled strobe.
module tick_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    output logic irq
);
    // Register the flag so the interrupt comes straight from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= expire;
        end
    end
endmodule

// File: rtl/periodic_tick_timer.sv
// periodic_tick_timer: top level of the programmable periodic tick interrupt.
// Wires the control word, the period counter and the interrupt register.
// Assumes: ref_tick is a one-cycle enable on clk; reset is synchronous.
module periodic_tick_timer #(
    parameter  int PERIOD_W = tick_pkg::DEF_PERIOD_W,
    localparam int REG_W    = PERIOD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    logic [REG_W-1:0]    cfg_q;
    logic                load_req;
    logic                stop_req;
    logic [PERIOD_W-1:0] load_val;
    logic                cnt_running;
    logic                cnt_expire;

    tick_ctrl_reg #(.PERIOD_W(PERIOD_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cfg_q      (cfg_q),
        .load_o     (load_req),
        .stop_o     (stop_req),
        .load_val_o (load_val)
    );

    tick_period_cnt #(.PERIOD_W(PERIOD_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .load       (load_req),
        .stop       (stop_req),
        .load_val   (load_val),
        .reload_val (cfg_q[PERIOD_W-1:0]),
        .running    (cnt_running),
        .expire     (cnt_expire)
    );

    tick_irq_out irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (cnt_expire),
        .irq    (irq)
    );

    // Expose the stored word for readback.
    always_comb rd_data = cfg_q;
endmodule

// File: rtl/periodic_tick_timer_chk.sv
// periodic_tick_timer_chk: protocol checks for the tick generator, bound in.
module periodic_tick_timer_chk #(
    parameter  int PERIOD_W = tick_pkg::DEF_PERIOD_W,
    localparam int REG_W    = PERIOD_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             irq,
    input logic             running
);
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    a_r6_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[PERIOD_W]) |=> !irq);

    a_r6_run_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
        running == rd_data[PERIOD_W]);

    a_r8_irq_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ref_tick));

    a_r9_write_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(wr_en));

    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_data[PERIOD_W]);
endmodule

bind periodic_tick_timer periodic_tick_timer_chk #(.PERIOD_W(PERIOD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq),
    .running  (cnt_running)
);

// File: tb/periodic_tick_timer_tb_top.sv
// periodic_tick_timer_tb_top: directed bench, one task per scenario.
module periodic_tick_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    periodic_tick_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 no irq after write", {7'd0, irq}, 8'h00);
    endtask

    // One strobe, then gap idle cycles in which irq must stay low (R8).
    task automatic tick(input int gap, output logic got);
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        got = irq;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check("R8 low between strobes", {7'd0, irq}, 8'h00);
        end
    endtask

    // Apply n strobes; irq expected exactly on every per-th strobe.
    task automatic run_ticks(input int n, input int per, input int gap, input string req);
        logic got;
        for (int k = 1; k <= n; k++) begin
            tick(gap, got);
            check(req, {7'd0, got}, {7'd0, (k % per) == 0});
        end
    endtask

    task automatic t_reset;
        check("R1 reset word", rd_data, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_readback;
        wr(8'h5A); check("R2 readback", rd_data, 8'h5A);
        wr(8'hFF); check("R2 readback", rd_data, 8'hFF);
        wr(8'h7F); check("R2 readback", rd_data, 8'h7F);
        wr(8'h00); check("R2 readback", rd_data, 8'h00);
    endtask

    task automatic t_first_and_repeat(input int n);
        wr(8'h80 | 8'(n));
        run_ticks(n + 1, n + 1, 2, "R3 first tick");
        run_ticks(2 * (n + 1), n + 1, 1, "R4 periodic repeat");
    endtask

    task automatic t_restart;
        wr(8'h85);
        run_ticks(3, 6, 0, "R5 before restart");
        wr(8'h85);
        run_ticks(6, 6, 1, "R5 full period after restart");
    endtask

    task automatic t_stop;
        wr(8'h83);
        run_ticks(2, 4, 0, "R6 before stop");
        wr(8'h03);
        run_ticks(10, 1000, 0, "R6 stopped");
        check("R6 word after stop", rd_data, 8'h03);
        wr(8'h83);
        run_ticks(4, 4, 0, "R6 re-enabled");
    endtask

    task automatic t_zero_period;
        wr(8'h80);
        run_ticks(4, 1, 2, "R7 every strobe");
        // Back-to-back strobes: irq high in each following cycle.
        @(negedge clk);
        ref_tick = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R7 back-to-back", {7'd0, irq}, 8'h01);
        end
        ref_tick = 1'b0;
        @(negedge clk);
        check("R8 one cycle pulse", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_coincide;
        // Block is running with N=0, so an uncounted strobe would fire.
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h82; ref_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ref_tick = 1'b0;
        check("R9 coincident strobe ignored", {7'd0, irq}, 8'h00);
        run_ticks(3, 3, 1, "R9 period after coincident write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_first_and_repeat(0);
        t_first_and_repeat(4);
        t_first_and_repeat(9);
        t_restart();
        t_stop();
        t_zero_period();
        t_coincide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule